// File: doc/BRIEF.md
# Serial EEPROM Target (I2C, 128 x 8)

This block is an I2C target that behaves like a small serial EEPROM holding 128 bytes. A fast system clock samples the SCL and SDA lines through synchronisers. The block detects START, repeated START and STOP on the sampled lines and accepts a device address made of the fixed prefix `1010` followed by three bits that must equal the `chip_sel` strap inputs. It acknowledges by pulling SDA low through an open-drain enable and returns read data the same way. `sda_release` is 1 when the line is released and 0 when the target pulls it low.

A write names a word address and then one or more data bytes, which go to consecutive locations. A random read first sends a write-mode device address and a word address. A repeated START and a read-mode device address follow, and the target then shifts out the byte at the stored pointer. The pointer survives the repeated START. While the master acknowledges each byte, reading continues from the next location. A master NACK ends the read.

Top module: `i2c_ee_target`

## Requirements
- R1: During and right after reset, `sda_release` is 1 and the target is idle.
- R2: A device byte is accepted only when its bits, sent MSB first, are `1010` followed by the three `chip_sel` bits (bit 3 down to bit 1 equal `chip_sel[2:0]`). Bit 0 selects the direction: 0 means write and 1 means read.
- R3: The target pulls SDA low during the ninth SCL clock that follows an accepted device byte, a word-address byte and each written data byte.
- R4: In a write, the byte after the device byte is the word address. Only its low 7 bits are used, so bit 7 is ignored. Each following byte is stored at the pointer.
- R5: After a write-mode device byte and a word address, a repeated START and a read-mode device byte make the target shift out the byte at the pointer, MSB first.
- R6: The pointer advances by one after every byte written or read and wraps from 127 to 0. Sequential reads go on for as long as the master acknowledges.
- R7: If the master does not acknowledge a read byte, the target releases SDA and stays released until the next START or STOP.
- R8: A device byte that does not match gets no acknowledge, and SDA stays released until the next START.
- R9: A START followed directly by a STOP leaves the target idle and released, and a following transaction works normally. A STOP always releases SDA.
- R10: The target changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| chip_sel | input | 3 | Strapped device-address bits |
| sda_release | output | 1 | 1 releases SDA, 0 pulls SDA low |

## Verification
The bench builds the block with its default parameters: 128 bytes of 8 bits and a two-stage synchroniser. With a depth of 128, the last location sits next to the wrap point, so a two-byte write at address 127 checks the pointer wrap, and the same holds for the read back. With 8-bit bytes, a word address with bit 7 set checks that the high bit is dropped. SCL runs at 32 system clocks per bit, which leaves room for the synchroniser delay before the target drives data while SCL is low.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK,
        ST_WORD,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } ee_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic dev_match(input logic [7:0] dev_byte, input logic [2:0] sel);
        return (dev_byte[7:4] == DEV_PREFIX) && (dev_byte[3:1] == sel);
    endfunction

endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync
    import i2c_ee_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[STAGES-2:0], sda_in};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    always_comb begin
        evt.scl      = scl_sh[STAGES-1];
        evt.sda      = sda_sh[STAGES-1];
        evt.scl_rise = evt.scl & ~scl_q;
        evt.scl_fall = ~evt.scl & scl_q;
        evt.start    = scl_q & evt.scl & sda_q & ~evt.sda;
        evt.stop     = scl_q & evt.scl & ~sda_q & evt.sda;
    end
endmodule

// File: rtl/ee_mem.sv
module ee_mem #(
    parameter int DEPTH = 128,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
    import i2c_ee_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  logic [2:0]    chip_sel,
    input  logic [DW-1:0] rd_data,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW-1:0] ptr,
    output logic          drv_low
);
    localparam int            CW       = $clog2(DW + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DW);
    localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

    ee_state_e     state;
    ee_state_e     nxt;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            nxt       <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            ptr       <= '0;
            drv_low   <= 1'b0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (evt.start) begin
                state   <= ST_DEV;
                cnt     <= '0;
                drv_low <= 1'b0;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                drv_low <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_WORD, ST_WDATA: begin
                        if (evt.scl_rise && cnt != CNT_FULL) begin
                            shreg <= {shreg[DW-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == CNT_FULL) begin
                            cnt <= '0;
                            if (state == ST_DEV) begin
                                if (dev_match(shreg[7:0], chip_sel)) begin
                                    drv_low <= 1'b1;
                                    state   <= ST_ACK;
                                    nxt     <= shreg[0] ? ST_RDATA : ST_WORD;
                                end else begin
                                    state <= ST_WAIT;
                                end
                            end else if (state == ST_WORD) begin
                                ptr     <= shreg[AW-1:0];
                                drv_low <= 1'b1;
                                state   <= ST_ACK;
                                nxt     <= ST_WDATA;
                            end else begin
                                mem_we    <= 1'b1;
                                mem_waddr <= ptr;
                                mem_wdata <= shreg;
                                ptr       <= ptr + 1'b1;
                                drv_low   <= 1'b1;
                                state     <= ST_ACK;
                                nxt       <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            state <= nxt;
                            cnt   <= '0;
                            if (nxt == ST_RDATA) begin
                                shreg   <= rd_data;
                                drv_low <= ~rd_data[DW-1];
                                ptr     <= ptr + 1'b1;
                            end else begin
                                drv_low <= 1'b0;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (evt.scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                drv_low <= 1'b0;
                                state   <= ST_RACK;
                            end else begin
                                cnt     <= cnt + 1'b1;
                                shreg   <= {shreg[DW-2:0], 1'b0};
                                drv_low <= ~shreg[DW-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise && evt.sda) begin
                            state <= ST_WAIT;
                        end else if (evt.scl_fall) begin
                            shreg   <= rd_data;
                            drv_low <= ~rd_data[DW-1];
                            ptr     <= ptr + 1'b1;
                            cnt     <= '0;
                            state   <= ST_RDATA;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target
    import i2c_ee_pkg::*;
#(
    parameter int MEM_DEPTH   = 128,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] chip_sel,
    output logic       sda_release
);
    localparam int AW = $clog2(MEM_DEPTH);

    bus_evt_t          evt;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] rd_data;
    logic [AW-1:0]     ptr;
    logic              drv_low;

    ee_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    ee_ctrl #(.AW(AW), .DW(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .chip_sel  (chip_sel),
        .rd_data   (rd_data),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .ptr       (ptr),
        .drv_low   (drv_low)
    );

    ee_mem #(.DEPTH(MEM_DEPTH), .WIDTH(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (ptr),
        .rdata (rd_data)
    );

    assign sda_release = ~drv_low;
endmodule

// File: rtl/ee_target_chk.sv
module ee_target_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          sda_release,
    input logic          scl_sync,
    input logic          stop_evt,
    input logic          mem_we,
    input logic [AW-1:0] mem_waddr,
    input logic [AW-1:0] ptr
);
    // R1: reset leaves the line released
    a_r1_reset_released: assert property (@(posedge clk) rst |=> sda_release);

    // R9: a STOP always frees SDA
    a_r9_stop_releases: assert property (@(posedge clk) disable iff (rst)
        stop_evt |=> sda_release);

    // R10: drive changes only follow a low synchronised SCL
    a_r10_change_scl_low: assert property (@(posedge clk) disable iff (rst)
        (sda_release != $past(sda_release)) |-> !$past(scl_sync));

    // R6: pointer is one past the location being written
    a_r6_ptr_advances: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (ptr == AW'(mem_waddr + 1'b1)));
endmodule

bind i2c_ee_target ee_target_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .sda_release (sda_release),
    .scl_sync    (evt.scl),
    .stop_evt    (evt.stop),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .ptr         (ptr)
);

// File: tb/tb_i2c_ee_target.sv
module tb_i2c_ee_target;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       msda = 1'b1;
    logic [2:0] sel = 3'b000;
    logic       sda_rel;
    logic       sda_bus;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    assign sda_bus = msda & sda_rel;

    always #10 clk = ~clk;

    i2c_ee_target dut (
        .clk         (clk),
        .rst         (rst),
        .scl_in      (scl),
        .sda_in      (sda_bus),
        .chip_sel    (sel),
        .sda_release (sda_rel)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_xfer(input logic d, output logic s);
        scl = 1'b0; waitq();
        msda = d;   waitq();
        scl = 1'b1; waitq();
        s = sda_bus; waitq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b1, s);
            d = {d[6:0], s};
        end
        bit_xfer(mack, s);
    endtask

    task automatic start_c();
        scl = 1'b0; waitq();
        msda = 1'b1; waitq();
        scl = 1'b1; waitq();
        msda = 1'b0; waitq();
    endtask

    task automatic stop_c();
        scl = 1'b0; waitq();
        msda = 1'b0; waitq();
        scl = 1'b1; waitq();
        msda = 1'b1; waitq();
    endtask

    task automatic ee_write(input logic [2:0] a, input logic [7:0] wa, input logic [7:0] d0,
                            input logic [7:0] d1, input bit two, input string tag);
        logic k;
        start_c();
        send_byte({4'b1010, a, 1'b0}, k); chk({tag, " R2 R3 dev ack"}, k, 1);
        send_byte(wa, k);                 chk({tag, " R3 word ack"}, k, 1);
        send_byte(d0, k);                 chk({tag, " R3 R4 data ack"}, k, 1);
        if (two) begin
            send_byte(d1, k);             chk({tag, " R6 second data ack"}, k, 1);
        end
        stop_c();
    endtask

    task automatic ee_read(input logic [2:0] a, input logic [7:0] wa, input logic [7:0] e0,
                           input logic [7:0] e1, input bit two, input string tag);
        logic       k;
        logic [7:0] d;
        start_c();
        send_byte({4'b1010, a, 1'b0}, k); chk({tag, " R3 dev ack"}, k, 1);
        send_byte(wa, k);                 chk({tag, " R3 word ack"}, k, 1);
        start_c();
        send_byte({4'b1010, a, 1'b1}, k); chk({tag, " R2 read dev ack"}, k, 1);
        recv_byte(~two, d);               chk({tag, " R5 first byte"}, d, e0);
        if (two) begin
            recv_byte(1'b1, d);           chk({tag, " R6 next byte"}, d, e1);
        end
        stop_c();
    endtask

    task automatic t_reset();
        chk("R1 released after reset", sda_rel, 1);
    endtask

    task automatic t_basic();
        sel = 3'b000;
        ee_write(3'b000, 8'h00, 8'h55, 8'h00, 0, "basic");
        ee_read(3'b000, 8'h00, 8'h55, 8'h00, 0, "basic");
    endtask

    task automatic t_strap111();
        sel = 3'b111;
        ee_write(3'b111, 8'h07, 8'hA5, 8'h00, 0, "strap111");
        ee_read(3'b111, 8'h07, 8'hA5, 8'h00, 0, "strap111");
        sel = 3'b000;
    endtask

    task automatic t_wrap();
        ee_write(3'b000, 8'h7F, 8'hA1, 8'h3C, 1, "R6 wrap");
        ee_read(3'b000, 8'h7F, 8'hA1, 8'h3C, 1, "R6 wrap");
    endtask

    task automatic t_addr_msb();
        ee_write(3'b000, 8'h85, 8'h77, 8'h00, 0, "R4 msb");
        ee_read(3'b000, 8'h05, 8'h77, 8'h00, 0, "R4 msb ignored");
    endtask

    task automatic t_mismatch();
        logic k;
        sel = 3'b010;
        start_c();
        send_byte(8'hA0, k); chk("R8 strap mismatch no ack", k, 0);
        send_byte(8'h00, k); chk("R8 stays released", k, 0);
        stop_c();
        start_c();
        send_byte(8'hB4, k); chk("R2 bad prefix no ack", k, 0);
        stop_c();
        ee_read(3'b010, 8'h05, 8'h77, 8'h00, 0, "R2 strap010");
        sel = 3'b000;
    endtask

    task automatic t_nack();
        logic       k;
        logic [7:0] d;
        ee_write(3'b000, 8'h10, 8'h11, 8'h22, 1, "R6 seq write");
        start_c();
        send_byte(8'hA0, k);
        send_byte(8'h10, k);
        start_c();
        send_byte(8'hA1, k);
        recv_byte(1'b1, d); chk("R7 byte before nack", d, 8'h11);
        recv_byte(1'b1, d); chk("R7 released after nack", d, 8'hFF);
        stop_c();
        ee_read(3'b000, 8'h11, 8'h22, 8'h00, 0, "R7 recover");
    endtask

    task automatic t_start_stop();
        start_c();
        msda = 1'b1; waitq();
        chk("R9 idle after start-stop", sda_rel, 1);
        ee_write(3'b000, 8'h20, 8'h9E, 8'h00, 0, "R9 after");
        ee_read(3'b000, 8'h20, 8'h9E, 8'h00, 0, "R9 after");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_start_stop();
        t_basic();
        t_strap111();
        t_wrap();
        t_addr_msb();
        t_mismatch();
        t_nack();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule